// File: doc/BRIEF.md
# Distributed ID-Based Bus Arbitration Cell

This block is the per-device half of a bus arbitration scheme that has no central arbiter. Every device that wants the bus carries one copy of the cell. All cells share a start strobe and a set of wired-OR arbitration lines. Each cell puts its own identifier on those lines, reads back the combined value, and withdraws bits where it sees that a higher identifier is present. After a few cycles, the only pattern left on the lines is the largest competing identifier. The cell that owns that identifier raises its win flag. Every other cell releases the lines completely.

A cell takes part only if its request input is high at the cycle where the start strobe rises. Dropping the start strobe ends the contest. All cells then return to idle, and any cell may compete again at the next rising edge of the strobe. The combined line value is fed back to every cell through `bus_i`. In a system, that value is the OR of the `drive_o` vectors of all cells.

Withdrawal uses a registered mask. This keeps the feedback loop through the wired lines free of combinational cycles. A verdict is reached only once the line value has stayed the same for `SETTLE` consecutive samples. A constant line value is a true fixed point of the withdrawal rule, so no cell can win on a transient pattern.

Top module: `darb_cell`

## Requirements
- R1: After reset, `drive_o` is 0 and `win_o` is 0.
- R2: A cell whose `req_i` is low at the rising edge of `start_i` drives 0 on every line and never wins during that contest.
- R3: A cell whose `req_i` is high when `start_i` rises drives its full `dev_id_i` on `drive_o` in the cycle after the rising edge is sampled.
- R4: While arbitrating, at each clock edge the cell finds the highest bit position p where `bus_i` is 1 and its own ID bit is 0. From the next cycle it drives only the ID bits above p. If there is no such position, it drives its whole ID. `drive_o` never has a 1 where `dev_id_i` has a 0.
- R5: Among the requesting cells in one contest, whose IDs are distinct, exactly the cell with the numerically largest ID asserts `win_o`.
- R6: `win_o` rises only after `bus_i` has equalled the cell's ID for `SETTLE` consecutive samples (default 2). A lone requester therefore asserts `win_o` 3 cycles after start is raised. While `win_o` is high, `drive_o` equals `dev_id_i` and `bus_i` equals `dev_id_i`.
- R7: A requesting cell that does not win drives 0 on all lines and keeps `win_o` at 0 once the line value has settled.
- R8: One cycle after `start_i` is sampled low, `drive_o` is 0 and `win_o` is 0, whatever the earlier state.
- R9: A cell that lost a contest competes again at the next rising edge of `start_i` and can win it.
- R10: In a contest with at least one requester, the winner asserts `win_o` no later than `ID_W + SETTLE + 4` cycles after start is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Shared start strobe; a rising edge begins a contest, low ends it |
| req_i | input | 1 | Wish to compete, sampled at the rising edge of start |
| dev_id_i | input | ID_W | This cell's identifier |
| bus_i | input | ID_W | Combined value of the wired-OR arbitration lines |
| drive_o | output | ID_W | Bits this cell places on the arbitration lines |
| win_o | output | 1 | High while this cell holds the win |

## Verification
A wrong withdrawal mask appears on `drive_o` in the very next cycle. It shows either as bits kept above a beaten position or as bits dropped with no reason, and the R4 snapshot taken two cycles after start exposes it. A stale or miscounted settle counter shifts the rising edge of `win_o` away from the third cycle for a lone requester. It can also let a lower ID win on a transient pattern, which shows as two cells winning or the wrong cell winning within the latency bound. A state that fails to leave the contest leaves lines driven or `win_o` high one cycle after start drops.

// File: rtl/darb_pkg.sv
package darb_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ARB  = 2'd1,
      ST_WON  = 2'd2,
      ST_LOST = 2'd3
   } darb_state_e;

endpackage

// File: rtl/darb_withdraw.sv
module darb_withdraw #(
   parameter int ID_W = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load_i,
   input  logic            upd_i,
   input  logic [ID_W-1:0] id_i,
   input  logic [ID_W-1:0] bus_i,
   output logic [ID_W-1:0] mask_o
);

   logic [ID_W-1:0] beaten;
   logic [ID_W-1:0] keep;
   logic [ID_W-1:0] mask_q;

   assign beaten = bus_i & ~id_i;

   // a bit survives only if no beaten position sits at or above it
   for (genvar b = 0; b < ID_W; b++) begin : g_keep
      assign keep[b] = ((beaten >> b) == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      mask_q <= '0;
      else if (load_i) mask_q <= '1;
      else if (upd_i)  mask_q <= keep;
   end

   assign mask_o = mask_q;

endmodule

// File: rtl/darb_settle.sv
module darb_settle #(
   parameter int ID_W   = 4,
   parameter int SETTLE = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            active_i,
   input  logic [ID_W-1:0] bus_i,
   output logic            settled_o
);

   localparam int RUN_W = $clog2(SETTLE + 1);
   localparam logic [RUN_W-1:0] RUN_MAX  = RUN_W'(SETTLE);
   localparam logic [RUN_W-1:0] RUN_GOAL = RUN_W'(SETTLE - 2);

   logic [ID_W-1:0]  prev_q;
   logic             valid_q;
   logic [RUN_W-1:0] run_q;
   logic             same;

   assign same = (bus_i == prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         valid_q <= 1'b0;
         run_q   <= '0;
      end else if (!active_i) begin
         valid_q <= 1'b0;
         run_q   <= '0;
      end else begin
         prev_q  <= bus_i;
         valid_q <= 1'b1;
         if (!valid_q || !same) run_q <= '0;
         else if (run_q != RUN_MAX) run_q <= run_q + 1'b1;
      end
   end

   // SETTLE equal samples means SETTLE-1 matches in a row
   assign settled_o = active_i && valid_q && same && (run_q >= RUN_GOAL);

endmodule

// File: rtl/darb_fsm.sv
module darb_fsm
   import darb_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start_i,
   input  logic        req_i,
   input  logic        settled_i,
   input  logic        match_i,
   output darb_state_e state_o,
   output logic        load_o
);

   darb_state_e state_q, state_d;
   logic        start_q;
   logic        start_rise;

   assign start_rise = start_i && !start_q;
   assign load_o     = (state_q == ST_IDLE) && start_rise && req_i;

   always_comb begin
      state_d = state_q;
      if (!start_i) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE: if (load_o)    state_d = ST_ARB;
            ST_ARB:  if (settled_i) state_d = match_i ? ST_WON : ST_LOST;
            default: state_d = state_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         start_q <= 1'b0;
      end else begin
         state_q <= state_d;
         start_q <= start_i;
      end
   end

   assign state_o = state_q;

endmodule

// File: rtl/darb_cell.sv
module darb_cell
   import darb_pkg::*;
#(
   parameter int ID_W   = 4,
   parameter int SETTLE = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start_i,
   input  logic            req_i,
   input  logic [ID_W-1:0] dev_id_i,
   input  logic [ID_W-1:0] bus_i,
   output logic [ID_W-1:0] drive_o,
   output logic            win_o
);

   if (ID_W < 1 || ID_W > 16) begin : g_bad_width
      $error("darb_cell: ID_W must lie in 1..16");
   end
   if (SETTLE < 2 || SETTLE > 64) begin : g_bad_settle
      $error("darb_cell: SETTLE must lie in 2..64");
   end

   darb_state_e     state;
   logic            load;
   logic            settled;
   logic            in_arb;
   logic [ID_W-1:0] mask;

   assign in_arb = (state == ST_ARB);

   darb_fsm u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (start_i),
      .req_i     (req_i),
      .settled_i (settled),
      .match_i   (bus_i == dev_id_i),
      .state_o   (state),
      .load_o    (load)
   );

   darb_withdraw #(.ID_W(ID_W)) u_withdraw (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (load),
      .upd_i  (in_arb),
      .id_i   (dev_id_i),
      .bus_i  (bus_i),
      .mask_o (mask)
   );

   darb_settle #(.ID_W(ID_W), .SETTLE(SETTLE)) u_settle (
      .clk       (clk),
      .rst_n     (rst_n),
      .active_i  (in_arb),
      .bus_i     (bus_i),
      .settled_o (settled)
   );

   always_comb begin
      case (state)
         ST_ARB:  drive_o = dev_id_i & mask;
         ST_WON:  drive_o = dev_id_i;
         default: drive_o = '0;
      endcase
   end

   assign win_o = (state == ST_WON);

endmodule

// File: rtl/darb_cell_chk.sv
module darb_cell_chk #(
   parameter int ID_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start_i,
   input logic            req_i,
   input logic [ID_W-1:0] dev_id_i,
   input logic [ID_W-1:0] bus_i,
   input logic [ID_W-1:0] drive_o,
   input logic            win_o
);

   assert_rise_drives_id_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start_i) && req_i) |=> (drive_o == $past(dev_id_i)));

   assert_idle_when_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(start_i) && !req_i) |=> (drive_o == '0));

   assert_drive_within_id_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ((drive_o & ~dev_id_i) == '0));

   assert_win_matches_bus_R6: assert property (@(posedge clk) disable iff (!rst_n)
      win_o |-> (drive_o == dev_id_i && bus_i == dev_id_i));

   assert_win_after_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(win_o) |-> ($past(bus_i) == dev_id_i));

   assert_release_on_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> (drive_o == '0 && !win_o));

endmodule

bind darb_cell darb_cell_chk #(.ID_W(ID_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .start_i  (start_i),
   .req_i    (req_i),
   .dev_id_i (dev_id_i),
   .bus_i    (bus_i),
   .drive_o  (drive_o),
   .win_o    (win_o)
);

// File: tb/darb_cell_test.sv
module darb_cell_test;

   localparam int ID_W   = 4;
   localparam int SETTLE = 2;
   localparam int N_DEV  = 4;
   localparam int LAT    = ID_W + SETTLE + 4;

   logic                clk = 1'b0;
   logic                rst_n = 1'b0;
   logic                start = 1'b0;
   logic [N_DEV-1:0]    req = '0;
   logic [ID_W-1:0]     ids [N_DEV];
   logic [ID_W-1:0]     drv [N_DEV];
   logic [N_DEV-1:0]    win;
   logic [ID_W-1:0]     bus;

   logic [ID_W-1:0]     drv_n2 [N_DEV];
   logic [N_DEV-1:0]    win_n2;
   int                  first_win;
   int                  n_chk = 0;
   int                  n_fail = 0;

   always #10 clk = ~clk;

   always_comb begin
      bus = '0;
      for (int i = 0; i < N_DEV; i++) bus = bus | drv[i];
   end

   for (genvar g = 0; g < N_DEV; g++) begin : g_dev
      darb_cell #(.ID_W(ID_W), .SETTLE(SETTLE)) uut (
         .clk      (clk),
         .rst_n    (rst_n),
         .start_i  (start),
         .req_i    (req[g]),
         .dev_id_i (ids[g]),
         .bus_i    (bus),
         .drive_o  (drv[g]),
         .win_o    (win[g])
      );
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int exp_winner();
      int best = -1;
      for (int i = 0; i < N_DEV; i++)
         if (req[i] && (best < 0 || ids[i] > ids[best])) best = i;
      return best;
   endfunction

   task automatic do_round();
      int w;
      w = exp_winner();
      first_win = -1;
      @(negedge clk) start = 1'b1;
      @(negedge clk);
      for (int i = 0; i < N_DEV; i++) begin
         if (req[i]) chk(drv[i] == ids[i], "R3 full id driven", int'(drv[i]), int'(ids[i]));
         else        chk(drv[i] == '0, "R2 non-requester silent", int'(drv[i]), 0);
      end
      for (int k = 2; k <= LAT; k++) begin
         @(negedge clk);
         if (k == 2) begin
            for (int i = 0; i < N_DEV; i++) drv_n2[i] = drv[i];
            win_n2 = win;
         end
         if (win != '0 && first_win < 0) first_win = k;
      end
      if (w >= 0) begin
         chk(first_win >= 0 && first_win <= LAT, "R10 win latency", first_win, LAT);
         chk($countones(win) == 1, "R5 single winner", $countones(win), 1);
         chk(win[w] == 1'b1, "R5 highest id wins", int'(win), 1 << w);
         chk(drv[w] == ids[w] && bus == ids[w], "R6 winner holds id", int'(bus), int'(ids[w]));
         for (int i = 0; i < N_DEV; i++)
            if (i != w) chk(drv[i] == '0 && !win[i], "R7 loser released", int'(drv[i]), 0);
      end
      @(negedge clk) start = 1'b0;
      @(negedge clk);
      chk(bus == '0 && win == '0, "R8 release on stop", int'({bus, win}), 0);
   endtask

   task automatic rand_ids();
      for (int i = 0; i < N_DEV; i++) begin
         bit dup;
         do begin
            ids[i] = ID_W'($urandom_range(15, 0));
            dup = 1'b0;
            for (int j = 0; j < i; j++) if (ids[j] == ids[i]) dup = 1'b1;
         end while (dup);
      end
   endtask

   initial begin
      int unsigned seed;
      seed = $urandom(32'd4711);
      for (int i = 0; i < N_DEV; i++) ids[i] = ID_W'(i + 1);
      repeat (3) @(negedge clk);
      chk(bus == '0 && win == '0, "R1 reset state", int'({bus, win}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(bus == '0 && win == '0, "R1 after reset release", int'({bus, win}), 0);

      // R4 directed: 0101 against 0110
      ids[0] = 4'b0101; ids[1] = 4'b0110; ids[2] = 4'b0000; ids[3] = 4'b0001;
      req = 4'b0011;
      do_round();
      chk(drv_n2[0] == 4'b0100, "R4 beaten bits withdrawn", int'(drv_n2[0]), 4);
      chk(drv_n2[1] == 4'b0110, "R4 winner keeps bits", int'(drv_n2[1]), 6);

      // R6 directed: lone requester timing
      ids[2] = 4'b1010; req = 4'b0100;
      do_round();
      chk(win_n2 == '0, "R6 no early win", int'(win_n2), 0);
      chk(first_win == 3, "R6 lone win cycle", first_win, 3);

      // R9 directed: loser retries
      ids[0] = 4'd9; ids[1] = 4'd12; req = 4'b0011;
      do_round();
      req = 4'b0001;
      do_round();
      chk(win_n2 == '0 && first_win == 3, "R9 retry wins", first_win, 3);

      // R2 directed: nobody requests
      req = 4'b0000;
      do_round();
      chk(first_win < 0, "R2 no requester no win", first_win, -1);

      for (int r = 0; r < 40; r++) begin
         rand_ids();
         do req = N_DEV'($urandom_range(15, 0)); while (req == '0);
         do_round();
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(200000 * 20);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule